// File: doc/BRIEF.md
# Phase Drift Detector for a Free-Running Oscillator

The block watches a free-running oscillator and produces a one-bit correction that, once averaged by an external integrator, steers the oscillator's tuning element. The oscillator clocks a single toggle flop. That flop's state is the parity of the oscillator's rising edges. The toggle bit crosses into the system clock domain through a two-flop synchroniser. A divider then samples it once per sampling period.

Each sample enters a long serial delay line, built as a circular buffer in a one-bit-wide memory with one read and one write per sample. The correction output is the XOR of the new sample and the sample taken one line length earlier. It is registered and refreshed on every sample, even when no correction is needed. The integrator removes the resulting sample-to-sample chatter. Stable lock points fall every 2·fs/N in oscillator frequency, where fs is the sample rate and N the line length. The defaults are a 20 MHz clock divided by 2000 (10 kHz) and N = 2000, which gives 10 Hz spacing.

There is no data stream at the block's edges, so no valid/ready handshake applies: the oscillator input is a clock, and the correction is a level that downstream analog circuitry consumes continuously. Back-pressure does not arise.

Top module: `phase_drift_detector`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, and from then until the first sample tick, `corr_out` is 0.
- R2: A sample tick occurs on the clock cycle in which `DIV_RATIO` clocks have elapsed since reset release or since the previous tick, so the first tick is the `DIV_RATIO`-th cycle after release. `corr_out` changes only at the edge that ends a tick cycle and holds its value between ticks.
- R3: Once the line has filled, at each tick `corr_out` becomes the new sample XOR the sample captured `LINE_LEN` ticks earlier.
- R4: For the first `LINE_LEN` ticks after a reset, the bit compared against is 0, so `corr_out` equals the new sample.
- R5: The sample is the oscillator toggle bit, 1 after an odd number of `osc_clk` rising edges since reset and 0 otherwise. A change of that bit at least three `clk` cycles before a tick is captured at that tick.
- R6: A reset asserted mid-run discards every stored sample, and the fill behaviour of R4 starts again.
- R7: With exactly one oscillator edge per sampling period and an even `LINE_LEN`, `corr_out` settles to 0 from the first tick after the line has filled with that pattern.
- R8: Two oscillator edges inside one sampling period leave the sample unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Reset, synchronous in the clock domain; it also clears the oscillator toggle flop asynchronously |
| osc_clk | input | 1 | Output of the oscillator under test |
| corr_out | output | 1 | Registered correction bit sent to the external integrator |

## Verification
A wrong read or write pointer, or a lost fill flag, appears at `corr_out` as a mismatch on some tick after the line first wraps. The delay is at most `LINE_LEN` ticks, because a corrupted entry is compared exactly one line length after it is written. A wrong divider state shows within one sampling period as an output edge off its tick cycle. A synchroniser fault shows at the first tick whose sample differs from its predecessor. The reference model compares the output on every clock, so any of these faults is flagged in the first cycle it reaches the port.

// File: rtl/dd_pkg.sv
package dd_pkg;
  // Counter width able to hold values 0..n-1, at least one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dd_osc_toggle.sv
module dd_osc_toggle (
  input  logic clk,
  input  logic rst,
  input  logic osc_clk,
  output logic tog_sync
);
  logic tog_osc;
  logic meta_q;
  logic sync_q;

  // Oscillator-domain parity flop; reset is applied asynchronously
  // because the oscillator domain has no reset of its own.
  always_ff @(posedge osc_clk or posedge rst) begin
    if (rst) tog_osc <= 1'b0;
    else     tog_osc <= ~tog_osc;
  end

  // Two-stage synchroniser into the system clock domain.
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= tog_osc;
      sync_q <= meta_q;
    end
  end

  assign tog_sync = sync_q;
endmodule

// File: rtl/dd_tick_gen.sv
module dd_tick_gen #(
  parameter int unsigned DIV_RATIO = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  import dd_pkg::*;
  localparam int unsigned CW = cnt_width(DIV_RATIO);
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dd_delay_line.sv
module dd_delay_line #(
  parameter int unsigned LINE_LEN = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic din,
  output logic dout
);
  import dd_pkg::*;
  localparam int unsigned PW = cnt_width(LINE_LEN);
  localparam logic [PW-1:0] LAST = PW'(LINE_LEN - 1);

  logic          mem [LINE_LEN];
  logic [PW-1:0] ptr_q;
  logic          full_q;

  // The slot at the pointer holds the oldest sample; it is read and then
  // overwritten in the same tick. Before the first wrap, its content
  // is stale, so zero is substituted.
  assign dout = full_q ? mem[ptr_q] : 1'b0;

  always_ff @(posedge clk) begin
    if (step) mem[ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (step) begin
      if (ptr_q == LAST) begin
        ptr_q  <= '0;
        full_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_drift_detector.sv
module phase_drift_detector #(
  parameter int unsigned DIV_RATIO = 2000,
  parameter int unsigned LINE_LEN  = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_clk,
  output logic corr_out
);
  logic tick;
  logic samp_bit;
  logic aged_bit;
  logic corr_q;

  dd_osc_toggle u_tog (
    .clk      (clk),
    .rst      (rst),
    .osc_clk  (osc_clk),
    .tog_sync (samp_bit)
  );

  dd_tick_gen #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dd_delay_line #(.LINE_LEN(LINE_LEN)) u_line (
    .clk  (clk),
    .rst  (rst),
    .step (tick),
    .din  (samp_bit),
    .dout (aged_bit)
  );

  // Compare happens before the shift: the aged bit is the one already
  // in the last position when the new sample arrives.
  always_ff @(posedge clk) begin
    if (rst)       corr_q <= 1'b0;
    else if (tick) corr_q <= samp_bit ^ aged_bit;
  end

  assign corr_out = corr_q;
endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
  parameter int unsigned DIV_RATIO = 2000,
  parameter int unsigned LINE_LEN  = 2000
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic samp,
  input logic corr_out
);
  localparam int unsigned GW = $clog2(DIV_RATIO + 1);
  localparam int unsigned FW = $clog2(LINE_LEN + 1);

  logic [GW-1:0] gap_q;
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst || tick)                  gap_q <= '0;
    else if (gap_q != GW'(DIV_RATIO)) gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                    fill_q <= '0;
    else if (tick && fill_q != FW'(LINE_LEN))   fill_q <= fill_q + 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !corr_out); // R1

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == GW'(DIV_RATIO - 1))); // R2

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(corr_out)); // R2

  AST_FILL_PASS: assert property (@(posedge clk) disable iff (rst)
    (tick && fill_q < FW'(LINE_LEN)) |=> (corr_out == $past(samp))); // R4
endmodule

bind phase_drift_detector dd_checker #(
  .DIV_RATIO(DIV_RATIO),
  .LINE_LEN (LINE_LEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .samp     (samp_bit),
  .corr_out (corr_out)
);

// File: tb/phase_drift_detector_bench.sv
`timescale 1ns/100ps
module phase_drift_detector_bench;
  localparam int unsigned DIV = 8;
  localparam int unsigned LEN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_clk = 1'b0;
  logic corr_out;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  string tag = "R1";

  // Reference model state
  bit  tog = 1'b0;
  bit  exp_corr = 1'b0;
  int  m_div = 0;
  bit  line_q[$];

  phase_drift_detector #(.DIV_RATIO(DIV), .LINE_LEN(LEN)) u_phase_drift_detector (
    .clk      (clk),
    .rst      (rst),
    .osc_clk  (osc_clk),
    .corr_out (corr_out)
  );

  always #2.5 clk = ~clk;

  // Behavioural model: counts cycles, keeps a queue of past samples.
  always @(posedge clk) begin
    if (rst) begin
      m_div = 0;
      exp_corr = 1'b0;
      line_q.delete();
    end else if (m_div == DIV - 1) begin
      bit aged;
      aged = (line_q.size() == LEN) ? line_q.pop_front() : 1'b0;
      exp_corr = tog ^ aged;
      line_q.push_back(tog);
      m_div = 0;
    end else begin
      m_div = m_div + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (corr_out !== exp_corr) begin
        n_fail++;
        $display("FAIL %s: corr_out=%0b expected %0b at %0t", tag, corr_out, exp_corr, $time);
      end
    end
  end

  task automatic osc_edges(input int n);
    for (int k = 0; k < n; k++) begin
      osc_clk = 1'b1; #0.5;
      osc_clk = 1'b0; #0.5;
      tog = ~tog;
    end
  endtask

  // mode 0: no edges, 1: one edge, 2: random 0..2, 3: two edges per period
  task automatic run_ticks(input int n, input int mode);
    for (int i = 0; i < n * DIV; i++) begin
      @(negedge clk);
      if (!rst && m_div == 1) begin
        case (mode)
          1: osc_edges(1);
          2: osc_edges($urandom_range(2, 0));
          3: osc_edges(2);
          default: ;
        endcase
      end
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    tog = 1'b0;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    tag = "R1";
    repeat (5) @(negedge clk);
    rst = 1'b0;
    tag = "R1 R2";
    run_ticks(1, 0);
    tag = "R4 R5";
    run_ticks(LEN, 2);
    tag = "R3 R5";
    run_ticks(40, 2);
    tag = "R7";
    run_ticks(LEN + 10, 1);
    tag = "R8";
    run_ticks(20, 3);
    tag = "R6";
    run_ticks(1, 2);
    repeat (3) @(negedge clk);
    do_reset(3);
    tag = "R6 R4";
    run_ticks(LEN, 2);
    tag = "R2 R3";
    run_ticks(30, 2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      summary();
      $finish;
    end
  end
endmodule